// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits between a byte-wide host write bus and the control back-end of an eight-sector flash array. Each sector holds 64 KB, and a 19-bit byte address picks the sector with its top three bits. Host writes do not go to the array directly. The decoder treats each one as a byte of a keyed command sequence. Only after a complete and correct sequence does it raise a single-cycle command pulse toward the back-end. The commands are program, sector erase, block erase, suspend, resume and reset.

Every sequence opens with a two-write unlock key, AAh at 5555h followed by 55h at 2AAAh, and then a command byte at 5555h. Erase needs a second unlock key before its confirm byte. Sector erase collects more sector addresses inside a sliding window, and the erase starts when that window closes without a new address.

A per-sector protect vector keeps program and erase away from the sectors it marks. While an erase runs, the decoder listens only for suspend, and while the erase is suspended it listens only for resume. The back-end marks the end of an erase with a done strobe.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset every command pulse is low, `erase_mask` is 00h and `erase_active` is 0.
- R2: AAh@5555h, 55h@2AAAh, A0h@5555h, then one write at any address makes `cmd_prog` high for one cycle in the cycle after that last write, carrying its address on `prog_addr` and its data on `prog_data`.
- R3: Unlock and command addresses are compared on address bits 14:0 only, so 7D555h matches 5555h and 12AAAh matches 2AAAh.
- R4: A write carrying a wrong value or address at any step of a sequence returns the decoder to read state, and no command pulse follows from the bytes already received.
- R5: In a sequence, a gap of up to TMO_CYC clock cycles between two write strobes is accepted. A gap of TMO_CYC+1 cycles returns the decoder to read state.
- R6: F0h written at any address while the decoder is in read state or partway through an unlock or erase sequence raises `cmd_reset` for one cycle and returns to read state. It is not treated this way as the program data byte, nor while an erase runs or is suspended.
- R7: After AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, each 30h write adds bit addr[18:16] to the sector mask. When GATHER_CYC cycles pass after the last such write with no further write, `cmd_sect_erase` pulses with `erase_mask` set to that mask, one cycle later, and `erase_active` rises.
- R8: After the erase prefix and second unlock, 10h@5555h pulses `cmd_block_erase` in the next cycle with `erase_mask` equal to the inverse of `sect_prot`.
- R9: A sector whose `sect_prot` bit is 1 is never programmed and never appears in `erase_mask`. If every requested sector is protected, no erase pulse is issued and `erase_active` stays 0.
- R10: While an erase runs, any write other than B0h has no effect. B0h pulses `cmd_suspend`. While suspended, only 30h has an effect: it pulses `cmd_resume` and the erase runs again.
- R11: While sector addresses are being gathered, a write other than 30h or F0h drops the pending erase.
- R12: An `erase_done` strobe while an erase runs clears `erase_active`, and the decoder accepts new sequences after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | 19 | Write byte address, bits 18:16 select the sector |
| wr_data | input | 8 | Write data byte |
| sect_prot | input | 8 | Per-sector protect flags, 1 means protected |
| erase_done | input | 1 | Back-end strobe at the end of an erase |
| cmd_prog | output | 1 | Program command pulse |
| prog_addr | output | 19 | Program target address |
| prog_data | output | 8 | Program data byte |
| cmd_sect_erase | output | 1 | Sector erase command pulse |
| cmd_block_erase | output | 1 | Block erase command pulse |
| erase_mask | output | 8 | Sectors the erase covers |
| cmd_suspend | output | 1 | Erase suspend pulse |
| cmd_resume | output | 1 | Erase resume pulse |
| cmd_reset | output | 1 | Reset-to-read pulse |
| erase_active | output | 1 | An erase is running or suspended |

## Verification
Program sequences are run with clean keys, with keys whose addresses alias in the upper bits, and with a wrong value or a wrong address at one step. Together these separate full-address from 15-bit key matching, and show whether an abort truly discards the bytes already received. The timeout is driven with gaps one cycle either side of the limit. The gather window is sampled one cycle before and at the moment the erase pulse is due, which shows whether the window restarts on each new sector address. Erase runs with mixed protect patterns, with every sector protected, and with stray writes while the erase is running or suspended. These separate mask filtering, the empty-erase case, and the filter that lets only suspend and resume through.

// File: rtl/flash_cmd_pkg.sv
// Shared state encoding and command constants for the flash command decoder.
// Assumes unlock keys are compared on a 15-bit key address.
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_KEY1,
        ST_KEY2,
        ST_PROG_ARM,
        ST_ERA_ARM,
        ST_ERA_KEY1,
        ST_ERA_KEY2,
        ST_GATHER,
        ST_ERASING,
        ST_SUSPENDED
    } seq_state_t;

    localparam int KEY_ADDR_W = 15;

    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_FIRST  = 15'h5555;
    localparam logic [KEY_ADDR_W-1:0] KEY_ADDR_SECOND = 15'h2AAA;

    localparam logic [7:0] BYTE_KEY_FIRST  = 8'hAA;
    localparam logic [7:0] BYTE_KEY_SECOND = 8'h55;
    localparam logic [7:0] BYTE_PROGRAM    = 8'hA0;
    localparam logic [7:0] BYTE_ERASE_PRE  = 8'h80;
    localparam logic [7:0] BYTE_SECTOR     = 8'h30;
    localparam logic [7:0] BYTE_BLOCK      = 8'h10;
    localparam logic [7:0] BYTE_SUSPEND    = 8'hB0;
    localparam logic [7:0] BYTE_RESUME     = 8'h30;
    localparam logic [7:0] BYTE_RESET      = 8'hF0;

endpackage

// File: rtl/flash_addr_decode.sv
// Address decode for the command decoder: flags the two key addresses using
// the low key bits only, and extracts the sector index from the top bits.
// Assumes ADDR_W covers at least the key bits plus the sector bits.
module flash_addr_decode
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              at_key_first,
    output logic              at_key_second,
    output logic [SECT_W-1:0] sector
);
    localparam int MID_W = ADDR_W - SECT_W - KEY_ADDR_W;

    logic [KEY_ADDR_W-1:0] key_bits;
    logic [MID_W-1:0]      unused_mid;

    // Split the address into key bits, unused middle bits and sector bits.
    always_comb begin
        key_bits   = addr[KEY_ADDR_W-1:0];
        unused_mid = addr[ADDR_W-SECT_W-1:KEY_ADDR_W];
        sector     = addr[ADDR_W-1:ADDR_W-SECT_W];
    end

    // Compare the key bits against the two unlock addresses.
    always_comb begin
        at_key_first  = (key_bits == KEY_ADDR_FIRST);
        at_key_second = (key_bits == KEY_ADDR_SECOND);
    end

endmodule

// File: rtl/flash_seq_timer.sv
// Inter-byte and gather-window timer. Counts idle cycles while running and
// restarts on every write. Flags expiry in the cycle the count reaches the
// selected limit minus one. Assumes both limits are at least 2.
module flash_seq_timer #(
    parameter int TMO_CYC    = 64,
    parameter int GATHER_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic use_gather,
    output logic expired
);
    localparam int MAX_CYC = (TMO_CYC > GATHER_CYC) ? TMO_CYC : GATHER_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] TMO_LAST    = CNT_W'(TMO_CYC - 1);
    localparam logic [CNT_W-1:0] GATHER_LAST = CNT_W'(GATHER_CYC - 1);

    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] limit;

    // Idle-cycle counter, cleared on writes and outside timed states.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !run) begin
            count <= '0;
        end else if (count != limit) begin
            count <= count + 1'b1;
        end
    end

    // Pick the limit for the current state and raise expiry on reaching it.
    always_comb begin
        limit   = use_gather ? GATHER_LAST : TMO_LAST;
        expired = run && !restart && (count == limit);
    end

endmodule

// File: rtl/flash_sector_gather.sv
// Gathers the sector mask for a sector erase, one bit per sector. A sector
// is added only if its protect flag is clear when its address arrives.
// Assumes the caller clears the mask before each new erase sequence.
module flash_sector_gather #(
    parameter int N_SECT = 8,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add,
    input  logic [SECT_W-1:0] sector,
    input  logic [N_SECT-1:0] prot,
    output logic [N_SECT-1:0] mask
);
    for (genvar i = 0; i < N_SECT; i++) begin : g_bit
        // Set this sector's bit when it is added and not protected.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                mask[i] <= 1'b0;
            end else if (add && (sector == SECT_W'(i)) && !prot[i]) begin
                mask[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Flash command sequence decoder. Turns host byte writes into single-cycle
// back-end commands after checking the unlock keys, enforcing the inter-byte
// timeout, and gathering sector addresses for erase. Assumes wr_en is a
// one-cycle strobe and that erase_done comes only while an erase runs.
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int N_SECT     = 8,
    parameter int TMO_CYC    = 64,
    parameter int GATHER_CYC = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [N_SECT-1:0] sect_prot,
    input  logic              erase_done,
    output logic              cmd_prog,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [7:0]        prog_data,
    output logic              cmd_sect_erase,
    output logic              cmd_block_erase,
    output logic [N_SECT-1:0] erase_mask,
    output logic              cmd_suspend,
    output logic              cmd_resume,
    output logic              cmd_reset,
    output logic              erase_active
);
    localparam int SECT_W = $clog2(N_SECT);

    seq_state_t        state, state_nx;
    logic              at_key_first, at_key_second;
    logic [SECT_W-1:0] wr_sector;
    logic [N_SECT-1:0] gather_mask;
    logic              timer_run, timer_gather, timer_expired;
    logic              gather_add, gather_clear;
    logic              in_seq, f0_hit, key1_ok, key2_ok;
    logic              prog_nx, sect_nx, block_nx, susp_nx, resume_nx, reset_nx;

    flash_addr_decode #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_dec (
        .addr          (wr_addr),
        .at_key_first  (at_key_first),
        .at_key_second (at_key_second),
        .sector        (wr_sector)
    );

    flash_seq_timer #(.TMO_CYC(TMO_CYC), .GATHER_CYC(GATHER_CYC)) u_tmr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (timer_run),
        .restart    (wr_en),
        .use_gather (timer_gather),
        .expired    (timer_expired)
    );

    flash_sector_gather #(.N_SECT(N_SECT), .SECT_W(SECT_W)) u_gth (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (gather_clear),
        .add    (gather_add),
        .sector (wr_sector),
        .prot   (sect_prot),
        .mask   (gather_mask)
    );

    // Qualify the incoming write against keys and the reset byte.
    always_comb begin
        key1_ok = wr_en && at_key_first  && (wr_data == BYTE_KEY_FIRST);
        key2_ok = wr_en && at_key_second && (wr_data == BYTE_KEY_SECOND);
        in_seq  = (state != ST_PROG_ARM) && (state != ST_ERASING) &&
                  (state != ST_SUSPENDED);
        f0_hit  = wr_en && in_seq && (wr_data == BYTE_RESET);
    end

    // Timer control: run in partial-sequence and gather states.
    always_comb begin
        timer_run    = (state != ST_READ) && (state != ST_ERASING) &&
                       (state != ST_SUSPENDED);
        timer_gather = (state == ST_GATHER);
        gather_clear = (state == ST_READ);
        gather_add   = wr_en && (wr_data == BYTE_SECTOR) && !f0_hit &&
                       ((state == ST_ERA_KEY2) || (state == ST_GATHER));
    end

    // Next-state and command decode for the sequence machine.
    always_comb begin
        state_nx  = state;
        prog_nx   = 1'b0;
        sect_nx   = 1'b0;
        block_nx  = 1'b0;
        susp_nx   = 1'b0;
        resume_nx = 1'b0;
        reset_nx  = 1'b0;
        if (f0_hit) begin
            reset_nx = 1'b1;
            state_nx = ST_READ;
        end else if (timer_expired) begin
            state_nx = ST_READ;
            if ((state == ST_GATHER) && (gather_mask != '0)) begin
                sect_nx  = 1'b1;
                state_nx = ST_ERASING;
            end
        end else begin
            unique case (state)
                ST_READ: begin
                    if (key1_ok) state_nx = ST_KEY1;
                end
                ST_KEY1: begin
                    if (wr_en) state_nx = key2_ok ? ST_KEY2 : ST_READ;
                end
                ST_KEY2: begin
                    if (wr_en) begin
                        state_nx = ST_READ;
                        if (at_key_first && wr_data == BYTE_PROGRAM)
                            state_nx = ST_PROG_ARM;
                        else if (at_key_first && wr_data == BYTE_ERASE_PRE)
                            state_nx = ST_ERA_ARM;
                    end
                end
                ST_PROG_ARM: begin
                    if (wr_en) begin
                        state_nx = ST_READ;
                        prog_nx  = !sect_prot[wr_sector];
                    end
                end
                ST_ERA_ARM: begin
                    if (wr_en) state_nx = key1_ok ? ST_ERA_KEY1 : ST_READ;
                end
                ST_ERA_KEY1: begin
                    if (wr_en) state_nx = key2_ok ? ST_ERA_KEY2 : ST_READ;
                end
                ST_ERA_KEY2: begin
                    if (wr_en) begin
                        state_nx = ST_READ;
                        if (wr_data == BYTE_SECTOR) begin
                            state_nx = ST_GATHER;
                        end else if (at_key_first && wr_data == BYTE_BLOCK &&
                                     (~sect_prot != '0)) begin
                            block_nx = 1'b1;
                            state_nx = ST_ERASING;
                        end
                    end
                end
                ST_GATHER: begin
                    if (wr_en && wr_data != BYTE_SECTOR) state_nx = ST_READ;
                end
                ST_ERASING: begin
                    if (wr_en && wr_data == BYTE_SUSPEND) begin
                        susp_nx  = 1'b1;
                        state_nx = ST_SUSPENDED;
                    end else if (erase_done) begin
                        state_nx = ST_READ;
                    end
                end
                ST_SUSPENDED: begin
                    if (wr_en && wr_data == BYTE_RESUME) begin
                        resume_nx = 1'b1;
                        state_nx  = ST_ERASING;
                    end
                end
                default: state_nx = ST_READ;
            endcase
        end
    end

    // State register and registered command pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state           <= ST_READ;
            cmd_prog        <= 1'b0;
            cmd_sect_erase  <= 1'b0;
            cmd_block_erase <= 1'b0;
            cmd_suspend     <= 1'b0;
            cmd_resume      <= 1'b0;
            cmd_reset       <= 1'b0;
        end else begin
            state           <= state_nx;
            cmd_prog        <= prog_nx;
            cmd_sect_erase  <= sect_nx;
            cmd_block_erase <= block_nx;
            cmd_suspend     <= susp_nx;
            cmd_resume      <= resume_nx;
            cmd_reset       <= reset_nx;
        end
    end

    // Command payload registers, loaded alongside their pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr  <= '0;
            prog_data  <= '0;
            erase_mask <= '0;
        end else begin
            if (prog_nx) begin
                prog_addr <= wr_addr;
                prog_data <= wr_data;
            end
            if (sect_nx)       erase_mask <= gather_mask;
            else if (block_nx) erase_mask <= ~sect_prot;
        end
    end

    // Erase phase flag seen by the host side.
    always_comb begin
        erase_active = (state == ST_ERASING) || (state == ST_SUSPENDED);
    end

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
// Assertion checker for the flash command decoder, attached by bind.
// Relates command pulses to the writes and protect flags that caused them.
module flash_cmd_decoder_chk #(
    parameter int ADDR_W = 19,
    parameter int N_SECT = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic [N_SECT-1:0] sect_prot,
    input logic              cmd_prog,
    input logic [ADDR_W-1:0] prog_addr,
    input logic              cmd_sect_erase,
    input logic              cmd_block_erase,
    input logic [N_SECT-1:0] erase_mask,
    input logic              cmd_suspend,
    input logic              cmd_resume,
    input logic              cmd_reset,
    input logic              erase_active
);
    localparam int SECT_W = $clog2(N_SECT);

    logic [N_SECT-1:0] prot_q;

    // Protect flags as seen at the edge that issued the last command.
    always_ff @(posedge clk) begin
        if (!rst_n) prot_q <= '0;
        else        prot_q <= sect_prot;
    end

    // At most one command pulse per cycle.
    a_r2_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_prog, cmd_sect_erase, cmd_block_erase,
                  cmd_suspend, cmd_resume, cmd_reset}));

    // R9: program never targets a protected sector.
    a_r9_prog_unprot: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_prog |-> !prot_q[prog_addr[ADDR_W-1:ADDR_W-SECT_W]]);

    // R9: an issued erase always covers at least one sector.
    a_r9_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sect_erase || cmd_block_erase) |-> (erase_mask != '0));

    // R7: sector erase starts on window expiry, never on a write edge.
    a_r7_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_sect_erase |-> $past(!wr_en));

    // R10: suspend follows a B0h write.
    a_r10_suspend_src: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_suspend |-> $past(wr_en && wr_data == 8'hB0));

    // R10: resume follows a 30h write and leaves the erase active.
    a_r10_resume_src: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_resume |-> ($past(wr_en && wr_data == 8'h30) && erase_active));

    // R6: reset pulse follows an F0h write.
    a_r6_reset_src: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |-> $past(wr_en && wr_data == 8'hF0));

    // R7: erase becomes active together with the start pulse.
    a_r7_active_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sect_erase || cmd_block_erase) |-> erase_active);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(
    .ADDR_W (ADDR_W),
    .N_SECT (N_SECT)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_data         (wr_data),
    .sect_prot       (sect_prot),
    .cmd_prog        (cmd_prog),
    .prog_addr       (prog_addr),
    .cmd_sect_erase  (cmd_sect_erase),
    .cmd_block_erase (cmd_block_erase),
    .erase_mask      (erase_mask),
    .cmd_suspend     (cmd_suspend),
    .cmd_resume      (cmd_resume),
    .cmd_reset       (cmd_reset),
    .erase_active    (erase_active)
);

// File: tb/flash_cmd_decoder_test.sv
// Directed bench for the flash command decoder, one task per scenario.
module flash_cmd_decoder_test;
    localparam int TMO = 20;
    localparam int GW  = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  sect_prot = '0;
    logic        erase_done = 1'b0;
    logic        cmd_prog, cmd_sect_erase, cmd_block_erase;
    logic        cmd_suspend, cmd_resume, cmd_reset, erase_active;
    logic [18:0] prog_addr;
    logic [7:0]  prog_data, erase_mask;

    int n_checks = 0;
    int n_fail   = 0;

    flash_cmd_decoder #(.ADDR_W(19), .N_SECT(8), .TMO_CYC(TMO),
                        .GATHER_CYC(GW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sect_prot(sect_prot), .erase_done(erase_done),
        .cmd_prog(cmd_prog), .prog_addr(prog_addr), .prog_data(prog_data),
        .cmd_sect_erase(cmd_sect_erase), .cmd_block_erase(cmd_block_erase),
        .erase_mask(erase_mask), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
        .erase_active(erase_active)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] pulses();
        return {cmd_prog, cmd_sect_erase, cmd_block_erase,
                cmd_suspend, cmd_resume, cmd_reset};
    endfunction

    task automatic bus_wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic unlock();
        bus_wr(19'h05555, 8'hAA);
        bus_wr(19'h02AAA, 8'h55);
    endtask

    task automatic end_erase();
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(1);
        check("R1 pulses", 32'(pulses()), 0);
        check("R1 mask", 32'(erase_mask), 0);
        check("R1 active", 32'(erase_active), 0);
    endtask

    task automatic t_program();
        unlock(); bus_wr(19'h05555, 8'hA0); bus_wr(19'h3_1234, 8'h5A);
        check("R2 prog pulse", 32'(cmd_prog), 1);
        check("R2 prog addr", 32'(prog_addr), 32'h3_1234);
        check("R2 prog data", 32'(prog_data), 32'h5A);
        idle(1);
        check("R2 prog one cycle", 32'(cmd_prog), 0);
        // R3: aliased key addresses
        bus_wr(19'h7D555, 8'hAA); bus_wr(19'h12AAA, 8'h55);
        bus_wr(19'h45555, 8'hA0); bus_wr(19'h0_0007, 8'hC3);
        check("R3 alias prog", 32'(cmd_prog), 1);
        check("R3 alias data", 32'(prog_data), 32'hC3);
    endtask

    task automatic t_bad_seq();
        bus_wr(19'h05555, 8'hAA); bus_wr(19'h02AAB, 8'h55);
        bus_wr(19'h05555, 8'hA0); bus_wr(19'h0_0100, 8'h11);
        check("R4 bad addr no prog", 32'(cmd_prog), 0);
        unlock(); bus_wr(19'h05555, 8'h90); bus_wr(19'h0_0100, 8'h11);
        check("R4 bad cmd no prog", 32'(cmd_prog), 0);
        unlock(); bus_wr(19'h05555, 8'hA0); bus_wr(19'h0_0101, 8'h22);
        check("R4 recovers", 32'(cmd_prog), 1);
    endtask

    task automatic t_timeout();
        bus_wr(19'h05555, 8'hAA); idle(TMO - 2);
        bus_wr(19'h02AAA, 8'h55); bus_wr(19'h05555, 8'hA0);
        bus_wr(19'h0_0200, 8'h33);
        check("R5 gap at limit ok", 32'(cmd_prog), 1);
        bus_wr(19'h05555, 8'hAA); idle(TMO - 1);
        bus_wr(19'h02AAA, 8'h55); bus_wr(19'h05555, 8'hA0);
        bus_wr(19'h0_0200, 8'h33);
        check("R5 gap over limit", 32'(cmd_prog), 0);
    endtask

    task automatic t_reset_byte();
        unlock(); bus_wr(19'h0_0000, 8'hF0);
        check("R6 reset pulse", 32'(cmd_reset), 1);
        bus_wr(19'h05555, 8'hA0); bus_wr(19'h0_0300, 8'h44);
        check("R6 seq dropped", 32'(cmd_prog), 0);
        unlock(); bus_wr(19'h05555, 8'hA0); bus_wr(19'h0_0300, 8'hF0);
        check("R6 F0 as data", 32'({cmd_prog, cmd_reset}), 32'b10);
    endtask

    task automatic t_sector_erase();
        sect_prot = 8'h00;
        unlock(); bus_wr(19'h05555, 8'h80); unlock();
        bus_wr(19'h2_0000, 8'h30); idle(4);
        bus_wr(19'h5_1234, 8'h30);
        idle(GW - 1);
        check("R7 not before window", 32'(cmd_sect_erase), 0);
        idle(1);
        check("R7 erase pulse", 32'(cmd_sect_erase), 1);
        check("R7 mask", 32'(erase_mask), 32'h24);
        check("R7 active", 32'(erase_active), 1);
        end_erase();
        check("R12 done clears", 32'(erase_active), 0);
    endtask

    task automatic t_block_erase();
        sect_prot = 8'h81;
        unlock(); bus_wr(19'h05555, 8'h80); unlock();
        bus_wr(19'h05555, 8'h10);
        check("R8 block pulse", 32'(cmd_block_erase), 1);
        check("R8 block mask", 32'(erase_mask), 32'h7E);
        end_erase();
        sect_prot = 8'h00;
    endtask

    task automatic t_protect();
        sect_prot = 8'h10;
        unlock(); bus_wr(19'h05555, 8'hA0); bus_wr(19'h4_0000, 8'h01);
        check("R9 prot no prog", 32'(cmd_prog), 0);
        unlock(); bus_wr(19'h05555, 8'hA0); bus_wr(19'h3_0000, 8'h01);
        check("R9 unprot prog", 32'(cmd_prog), 1);
        unlock(); bus_wr(19'h05555, 8'h80); unlock();
        bus_wr(19'h4_0000, 8'h30); bus_wr(19'h1_0000, 8'h30);
        idle(GW);
        check("R9 mask filtered", 32'(erase_mask), 32'h02);
        end_erase();
        sect_prot = 8'hFF;
        unlock(); bus_wr(19'h05555, 8'h80); unlock();
        bus_wr(19'h6_0000, 8'h30); idle(GW + 2);
        check("R9 all prot no erase", 32'(erase_active), 0);
        unlock(); bus_wr(19'h05555, 8'h80); unlock();
        bus_wr(19'h05555, 8'h10);
        check("R9 all prot no block", 32'({cmd_block_erase, erase_active}), 0);
        sect_prot = 8'h00;
    endtask

    task automatic t_running();
        unlock(); bus_wr(19'h05555, 8'h80); unlock();
        bus_wr(19'h05555, 8'h10);
        bus_wr(19'h05555, 8'hAA);
        check("R10 ignore AA", 32'({pulses(), erase_active}), 1);
        bus_wr(19'h0_0000, 8'hF0);
        check("R10 ignore F0", 32'({pulses(), erase_active}), 1);
        bus_wr(19'h0_0000, 8'hB0);
        check("R10 suspend", 32'(cmd_suspend), 1);
        bus_wr(19'h0_0000, 8'hB0);
        check("R10 ignore in susp", 32'({pulses(), erase_active}), 1);
        bus_wr(19'h0_0000, 8'h30);
        check("R10 resume", 32'(cmd_resume), 1);
        end_erase();
        check("R12 done after resume", 32'(erase_active), 0);
        unlock(); bus_wr(19'h05555, 8'hA0); bus_wr(19'h0_0400, 8'h77);
        check("R12 new seq after erase", 32'(cmd_prog), 1);
    endtask

    task automatic t_gather_abort();
        unlock(); bus_wr(19'h05555, 8'h80); unlock();
        bus_wr(19'h3_0000, 8'h30); bus_wr(19'h3_0000, 8'h55);
        idle(GW + 2);
        check("R11 abort no erase", 32'(erase_active), 0);
        check("R11 abort no pulse", 32'(pulses()), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        t_reset();
        t_program();
        t_bad_seq();
        t_timeout();
        t_reset_byte();
        t_sector_erase();
        t_block_erase();
        t_protect();
        t_running();
        t_gather_abort();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule